// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block conditions a small set of external interrupt pins before they reach the chip's interrupt controller. Each pin first passes through a two-flop synchroniser. A per-input trigger mode then decides what counts as an event. The choices are a rising edge, a falling edge, either edge, an active-high level, an active-low level, or nothing at all. An event raises a pending bit. A pending bit whose enable bit is also set drives that input's request output.

Software uses a 32-bit register bus with four word registers:

| Offset | Contents |
|--------|----------|
| 0x0 | Trigger modes, one 4-bit nibble per input. Input i's 3-bit code sits in bits [4i+2:4i]. |
| 0x4 | A spare per-input control word that has no effect on the logic. |
| 0x8 | The pending bits. |
| 0xC | The enable bits. |

In an edge mode the pending bit is sticky and is cleared by writing a one to it. In a level mode the pending bit tracks the pin.

A driver brings an input into use in this order:
1. Pick the mode.
2. Clear any stale pending bit.
3. Set the enable bit.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset every input's mode code is 6 (active-low level), and the spare word, the enable bits, the pending bits and all request outputs are zero. Pins held high keep the pending bits at zero.
- R2: With mode code 1, a low-to-high change of pin i sets pending bit i. The request output changes on the third rising clock edge after the pin changes, and not on the second.
- R3: Mode code 2 sets pending on a high-to-low change only. Mode code 3 sets pending on a change in either direction.
- R4: In the edge modes (codes 1 to 3) a pending bit stays set until a bus write to offset 0x8 carries a one in bit i. Writing a zero leaves it set. An event on the same clock edge as the clearing write leaves the bit set.
- R5: With mode code 5 pending bit i equals the synchronised pin level. With code 6 it equals the inverted level. A write-one clear does not change it.
- R6: Request output i is high exactly when pending bit i and enable bit i are both set. The enable bits live in bits [N-1:0] of offset 0xC, and their upper bits read zero.
- R7: Mode codes 0, 4 and 7 never set a pending bit, whatever the pin does.
- R8: Writes to offset 0x0 keep only bits [4i+2:4i] of each nibble. Bit 4i+3 and all bits at 4N and above read back as zero.
- R9: Offset 0x4 stores bits [N-1:0] and reads them back, with the upper bits reading zero. Its value changes no pending bit and no request output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe; a write needs it high |
| bus_we | input | 1 | Write when high, together with bus_en |
| bus_addr | input | 4 | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| ext_pin | input | NUM_INPUTS | Asynchronous external interrupt pins |
| irq_req | output | NUM_INPUTS | Requests to the interrupt controller |

## Verification
The bench builds the unit with its defaults: six inputs and two synchroniser stages. Six inputs let one mode configuration put separate pins into rising, falling, both-edge, high-level and low-level modes at once, with other pins in the unused codes. The register readbacks show that nibble padding and the bits above 24 stay zero. Two synchroniser stages make the three-edge pin-to-request latency a fixed value that the bench samples on both sides. The bench also times a clearing write onto the exact edge where a new edge event lands.

// File: rtl/eitu_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the external interrupt trigger unit: mode codes,
// register word indices and field geometry.
package eitu_pkg;

    localparam int MODE_W   = 3;   // stored bits per input
    localparam int NIBBLE_W = 4;   // bits per input in the mode word
    localparam int REG_AW   = 4;   // byte address width of the register bus
    localparam int REG_DW   = 32;  // register data width

    // Trigger mode codes; 4 and 7 are reserved and act as "off".
    typedef enum logic [MODE_W-1:0] {
        TRIG_OFF   = 3'd0,
        TRIG_RISE  = 3'd1,
        TRIG_FALL  = 3'd2,
        TRIG_BOTH  = 3'd3,
        TRIG_RSV4  = 3'd4,
        TRIG_HIGH  = 3'd5,
        TRIG_LOW   = 3'd6,
        TRIG_RSV7  = 3'd7
    } trig_mode_e;

    // Word indices (byte address bits [3:2]).
    localparam logic [1:0] WIDX_MODE = 2'd0;
    localparam logic [1:0] WIDX_AUX  = 2'd1;
    localparam logic [1:0] WIDX_PEND = 2'd2;
    localparam logic [1:0] WIDX_EN   = 2'd3;

    // True for the three edge-detecting modes.
    function automatic logic mode_is_edge(input logic [MODE_W-1:0] m);
        return (m == TRIG_RISE) || (m == TRIG_FALL) || (m == TRIG_BOTH);
    endfunction

    // True for the two level-following modes.
    function automatic logic mode_is_level(input logic [MODE_W-1:0] m);
        return (m == TRIG_HIGH) || (m == TRIG_LOW);
    endfunction

endpackage

// File: rtl/eitu_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is an independent level signal; no bus coherency is kept.
// All stages reset to RESET_VAL so that idle pins cause no event after reset.
module eitu_sync #(
    parameter int   WIDTH     = 6,
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{{WIDTH{RESET_VAL}}}};
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/eitu_cell.sv
`timescale 1ns/1ps
// One trigger cell: turns a synchronised pin level into a pending bit.
// Edge modes compare with the previous synchronised level and make the bit
// sticky until a write-one clear; an event beats a clear in the same cycle.
// Level modes load the (optionally inverted) level every cycle.
// Off and reserved codes create no events; the bit holds and may be cleared.
module eitu_cell
    import eitu_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level,
    input  logic [MODE_W-1:0] mode,
    input  logic              clr,
    output logic              pend
);

    logic prev_q;
    logic pend_q;
    logic pend_d;
    logic rise_ev;
    logic fall_ev;

    assign rise_ev = level & ~prev_q;
    assign fall_ev = ~level & prev_q;

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RESET_LEVEL;
        else        prev_q <= level;
    end

    // Next pending value by trigger mode.
    always_comb begin
        unique case (mode)
            TRIG_RISE: pend_d = rise_ev | (pend_q & ~clr);
            TRIG_FALL: pend_d = fall_ev | (pend_q & ~clr);
            TRIG_BOTH: pend_d = rise_ev | fall_ev | (pend_q & ~clr);
            TRIG_HIGH: pend_d = level;
            TRIG_LOW:  pend_d = ~level;
            default:   pend_d = pend_q & ~clr;
        endcase
    end

    // Pending state register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

endmodule

// File: rtl/eitu_regs.sv
`timescale 1ns/1ps
// Register file of the trigger unit: mode word, spare control word and
// enable bits, plus read multiplexing and the write-one clear strobe for
// the pending bits that live in the cells. Assumes word-aligned accesses;
// byte address bits [1:0] are ignored.
module eitu_regs
    import eitu_pkg::*;
#(
    parameter int NUM_INPUTS = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_en,
    input  logic                             bus_we,
    input  logic [REG_AW-1:0]                bus_addr,
    input  logic [REG_DW-1:0]                bus_wdata,
    output logic [REG_DW-1:0]                bus_rdata,
    input  logic [NUM_INPUTS-1:0]            pend,
    output logic [NUM_INPUTS-1:0][MODE_W-1:0] mode,
    output logic [NUM_INPUTS-1:0]            enable,
    output logic [NUM_INPUTS-1:0]            clr
);

    logic [1:0]                            widx;
    logic                                  wr_hit;
    logic [NUM_INPUTS-1:0][MODE_W-1:0]     mode_q;
    logic [NUM_INPUTS-1:0]                 aux_q;
    logic [NUM_INPUTS-1:0]                 en_q;

    assign widx   = bus_addr[3:2];
    assign wr_hit = bus_en & bus_we;

    // Mode word: keep the low three bits of each input's nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_INPUTS; i++) mode_q[i] <= TRIG_LOW;
        end else if (wr_hit && widx == WIDX_MODE) begin
            for (int i = 0; i < NUM_INPUTS; i++)
                mode_q[i] <= bus_wdata[i*NIBBLE_W +: MODE_W];
        end
    end

    // Spare per-input control bits, stored only.
    always_ff @(posedge clk) begin
        if (!rst_n)                            aux_q <= '0;
        else if (wr_hit && widx == WIDX_AUX)   aux_q <= bus_wdata[NUM_INPUTS-1:0];
    end

    // Enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                            en_q <= '0;
        else if (wr_hit && widx == WIDX_EN)    en_q <= bus_wdata[NUM_INPUTS-1:0];
    end

    // Write-one clear strobe toward the pending cells.
    assign clr = (wr_hit && widx == WIDX_PEND) ? bus_wdata[NUM_INPUTS-1:0]
                                               : '0;

    // Read multiplexer; unused bits read zero.
    always_comb begin
        bus_rdata = '0;
        unique case (widx)
            WIDX_MODE: for (int i = 0; i < NUM_INPUTS; i++)
                           bus_rdata[i*NIBBLE_W +: MODE_W] = mode_q[i];
            WIDX_AUX:  bus_rdata[NUM_INPUTS-1:0] = aux_q;
            WIDX_PEND: bus_rdata[NUM_INPUTS-1:0] = pend;
            default:   bus_rdata[NUM_INPUTS-1:0] = en_q;
        endcase
    end

    assign mode   = mode_q;
    assign enable = en_q;

endmodule

// File: rtl/ext_irq_trigger.sv
`timescale 1ns/1ps
// External interrupt trigger unit, top level.
// Synchronises the pins, runs one trigger cell per input and gates the
// pending bits with the enable bits into the request outputs.
// Assumes NUM_INPUTS nibbles fit the 32-bit mode word (at most 8).
module ext_irq_trigger
    import eitu_pkg::*;
#(
    parameter int NUM_INPUTS  = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [REG_AW-1:0]     bus_addr,
    input  logic [REG_DW-1:0]     bus_wdata,
    output logic [REG_DW-1:0]     bus_rdata,
    input  logic [NUM_INPUTS-1:0] ext_pin,
    output logic [NUM_INPUTS-1:0] irq_req
);

    localparam logic IDLE_LEVEL = 1'b1;

    logic [NUM_INPUTS-1:0]             pin_sync;
    logic [NUM_INPUTS-1:0]             pend_w;
    logic [NUM_INPUTS-1:0]             en_w;
    logic [NUM_INPUTS-1:0]             clr_w;
    logic [NUM_INPUTS-1:0][MODE_W-1:0] mode_w;

    if (NUM_INPUTS * NIBBLE_W > REG_DW) begin : g_bad_cfg
        $error("NUM_INPUTS does not fit the mode word");
    end

    eitu_sync #(
        .WIDTH     (NUM_INPUTS),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (IDLE_LEVEL)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_pin),
        .sync_out (pin_sync)
    );

    eitu_regs #(
        .NUM_INPUTS (NUM_INPUTS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pend      (pend_w),
        .mode      (mode_w),
        .enable    (en_w),
        .clr       (clr_w)
    );

    for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_cell
        eitu_cell #(
            .RESET_LEVEL (IDLE_LEVEL)
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .level (pin_sync[i]),
            .mode  (mode_w[i]),
            .clr   (clr_w[i]),
            .pend  (pend_w[i])
        );
    end

    assign irq_req = pend_w & en_w;

endmodule

// File: rtl/eitu_checker.sv
`timescale 1ns/1ps
// Property checker for the trigger unit, bound into every instance.
module eitu_checker
    import eitu_pkg::*;
#(
    parameter int NUM_INPUTS = 6
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_INPUTS-1:0][MODE_W-1:0] mode,
    input logic [NUM_INPUTS-1:0]            lvl,
    input logic [NUM_INPUTS-1:0]            pend,
    input logic [NUM_INPUTS-1:0]            en,
    input logic [NUM_INPUTS-1:0]            clr,
    input logic [NUM_INPUTS-1:0]            req,
    input logic [REG_AW-1:0]                bus_addr,
    input logic [REG_DW-1:0]                bus_rdata
);

    for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_chk
        // R4: edge-mode pending stays set without a clear.
        a_r4_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_is_edge(mode[i]) && pend[i] && !clr[i]) |=> pend[i]);

        // R5: active-high level mode follows the synchronised level.
        a_r5_level_high: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] == TRIG_HIGH) |=> (pend[i] == $past(lvl[i])));

        // R5: active-low level mode follows the inverted level.
        a_r5_level_low: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] == TRIG_LOW) |=> (pend[i] == !$past(lvl[i])));

        // R6: no request without the enable bit.
        a_r6_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |-> !req[i]);

        // R7: off and reserved codes never raise a clear pending bit.
        a_r7_off_no_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_is_edge(mode[i]) && !mode_is_level(mode[i]) && !pend[i])
            |=> !pend[i]);

        // R8: nibble pad bit of the mode word reads zero.
        a_r8_nibble_pad: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr[3:2] == WIDX_MODE) |-> !bus_rdata[i*NIBBLE_W + MODE_W]);
    end

endmodule

bind ext_irq_trigger eitu_checker #(
    .NUM_INPUTS (NUM_INPUTS)
) u_eitu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_w),
    .lvl       (pin_sync),
    .pend      (pend_w),
    .en        (en_w),
    .clr       (clr_w),
    .req       (irq_req),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/ext_irq_trigger_bench.sv
`timescale 1ns/1ps
// Directed bench for the external interrupt trigger unit.
module ext_irq_trigger_bench;

    localparam int N = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  ext_pin = '1;
    logic [N-1:0]  irq_req;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    ext_irq_trigger #(.NUM_INPUTS(N), .SYNC_STAGES(2)) u_ext_irq_trigger (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_pin(ext_pin), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 req in reset", {26'd0, irq_req}, 32'h0);
        settle(1); rst_n = 1'b1; settle(4);
        rd(4'h0, d); check("R1 mode word", d, 32'h0066_6666);
        rd(4'h4, d); check("R1 spare word", d, 32'h0);
        rd(4'h8, d); check("R1 pending", d, 32'h0);
        rd(4'hC, d); check("R1 enable", d, 32'h0);
        check("R1 req", {26'd0, irq_req}, 32'h0);
    endtask

    task automatic t_mode_word();
        logic [31:0] d;
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d); check("R8 pad bits", d, 32'h0077_7777);
        wr(4'h0, 32'h0065_4321);
        rd(4'h0, d); check("R8 readback", d, 32'h0065_4321);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        wr(4'h0, 32'h0000_0001);
        ext_pin[0] = 1'b0; settle(3);
        wr(4'h8, 32'h3F); wr(4'hC, 32'h1);
        ext_pin[0] = 1'b1; settle(2);
        check("R2 not before third edge", {26'd0, irq_req}, 32'h0);
        settle(1);
        check("R2 req on third edge", {26'd0, irq_req}, 32'h1);
        ext_pin[0] = 1'b0; settle(3);
        rd(4'h8, d); check("R4 sticky after fall", d, 32'h1);
        wr(4'h8, 32'h0);
        rd(4'h8, d); check("R4 write zero keeps", d, 32'h1);
        wr(4'h8, 32'h1);
        rd(4'h8, d); check("R4 write one clears", d, 32'h0);
        check("R6 req drops", {26'd0, irq_req}, 32'h0);
        // Event and clear on the same edge.
        ext_pin[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr(4'h8, 32'h1);
        rd(4'h8, d); check("R4 event beats clear", d, 32'h1);
        wr(4'h8, 32'h1);
    endtask

    task automatic t_fall_both();
        logic [31:0] d;
        wr(4'h0, 32'h0000_0320);
        wr(4'h8, 32'h3F);
        ext_pin[1] = 1'b0; settle(3);
        rd(4'h8, d); check("R3 falling sets", d, 32'h2);
        wr(4'h8, 32'h2);
        ext_pin[1] = 1'b1; settle(3);
        rd(4'h8, d); check("R3 falling ignores rise", d, 32'h0);
        ext_pin[2] = 1'b0; settle(3);
        rd(4'h8, d); check("R3 both on fall", d, 32'h4);
        wr(4'h8, 32'h4);
        ext_pin[2] = 1'b1; settle(3);
        rd(4'h8, d); check("R3 both on rise", d, 32'h4);
        wr(4'h8, 32'h3F);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(4'h0, 32'h0006_5000);
        settle(3);
        rd(4'h8, d); check("R5 high level", d, 32'h08);
        wr(4'h8, 32'h08);
        rd(4'h8, d); check("R5 clear ignored", d, 32'h08);
        ext_pin[3] = 1'b0; ext_pin[4] = 1'b0; settle(3);
        rd(4'h8, d); check("R5 low level", d, 32'h10);
        ext_pin[3] = 1'b1; ext_pin[4] = 1'b1; settle(3);
        rd(4'h8, d); check("R5 released", d, 32'h08);
    endtask

    task automatic t_off();
        logic [31:0] d;
        wr(4'h0, 32'h0000_0740);
        wr(4'h8, 32'h3F);
        ext_pin[2:0] = 3'b000; settle(3);
        ext_pin[2:0] = 3'b111; settle(3);
        rd(4'h8, d); check("R7 off and reserved codes", d, 32'h0);
        check("R7 no request", {26'd0, irq_req}, 32'h0);
    endtask

    task automatic t_enable_aux();
        logic [31:0] d;
        wr(4'h0, 32'h0010_0000);
        ext_pin[5] = 1'b0; settle(3);
        ext_pin[5] = 1'b1; settle(3);
        check("R6 pending but disabled", {26'd0, irq_req}, 32'h0);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, d); check("R6 enable readback", d, 32'h3F);
        check("R6 enabled request", {26'd0, irq_req}, 32'h20);
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, d); check("R9 spare readback", d, 32'h3F);
        rd(4'h8, d); check("R9 pending untouched", d, 32'h20);
        check("R9 request untouched", {26'd0, irq_req}, 32'h20);
        wr(4'hC, 32'h0);
        check("R6 disabled again", {26'd0, irq_req}, 32'h0);
        rd(4'h8, d); check("R6 pending kept", d, 32'h20);
    endtask

    initial begin
        settle(2);
        t_reset();
        t_mode_word();
        t_rise();
        t_fall_both();
        t_level();
        t_off();
        t_enable_aux();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule